// File: doc/BRIEF.md
# Bidirectional Common Scan Shift Register

This block walks a scan token across the common (row) outputs of a dot-matrix display. A chain of `N` one-bit stages, one per common channel, advances by one position on each active edge of a line clock. The active edge is rising or falling, chosen by an input. Shift direction is chosen by a second input. Data enters at one serial end, and the bit that leaves the far stage appears at the other end so that further drivers can be cascaded.

In master mode the block makes its own token. A `1` enters on each line marked as the first of a frame, and a `0` enters on every other line, so exactly one channel is selected at a time. In slave mode the token comes in on whichever serial pin the direction select makes the input. Each serial pin is modelled as separate in, out and output-enable signals. For every channel the block combines the stage bit with the alternation signal into a 2-bit drive-level code for the analog drivers that follow it.

The line clock is treated as a level that is sampled in the system clock domain, and edges are found by comparing it with its previous sample. No storage element is clocked on both edges.

Top module: `com_scan_shifter`

## Requirements
- R1: A synchronous reset clears every stage to 0. Every channel then shows a non-select level, and both serial outputs read 0.
- R2: With `dir_fwd`=1, one active line-clock edge moves the serial input into channel 1 and moves channel k into channel k+1.
- R3: With `dir_fwd`=0, one active line-clock edge moves the serial input into channel N and moves channel k into channel k-1.
- R4: With `edge_rise_sel`=1 the chain shifts only when the sampled line clock goes 0→1. With `edge_rise_sel`=0 it shifts only when it goes 1→0. A line clock held at a constant level, or moving in the other direction, leaves every stage unchanged.
- R5: In master mode (`master_mode`=1) the serial input is `frame_start`, and both pin inputs are ignored. In slave mode the serial input is `port_a_in` when `dir_fwd`=1 and `port_b_in` when `dir_fwd`=0.
- R6: In master mode `port_a_oe` and `port_b_oe` are both 1, whatever the value of `dir_fwd`. Each enable is registered and follows the mode one clock later.
- R7: In slave mode `port_a_oe`=0 and `port_b_oe`=1 when `dir_fwd`=1, and `port_a_oe`=1 and `port_b_oe`=0 when `dir_fwd`=0. Both enables are registered, with one clock of latency.
- R8: The level code of channel k is `level_code[2k-1:2k-2]`. The code depends on the stage bit and `alt_m` as follows. Bit 0 with `alt_m` 0 gives 01 (non-select low). Bit 0 with `alt_m` 1 gives 10 (non-select high). Bit 1 with `alt_m` 0 gives 11 (select low). Bit 1 with `alt_m` 1 gives 00 (select high). The code is registered one clock after the stage and `alt_m`.
- R9: `port_a_out` always carries the channel 1 stage and `port_b_out` the channel N stage. A token injected at one end therefore shows on the far-end pin after exactly N active edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Line shift clock, sampled on clk |
| edge_rise_sel | input | 1 | 1: shift on rising line-clock edge, 0: on falling |
| dir_fwd | input | 1 | 1: channel 1 toward N, 0: channel N toward 1 |
| master_mode | input | 1 | 1: master (internal token), 0: slave |
| frame_start | input | 1 | First line of frame marker, token source in master mode |
| alt_m | input | 1 | Drive alternation signal |
| port_a_in | input | 1 | Channel-1-end serial pin, input side |
| port_a_out | output | 1 | Channel-1-end serial pin, output side |
| port_a_oe | output | 1 | Channel-1-end serial pin drive enable |
| port_b_in | input | 1 | Channel-N-end serial pin, input side |
| port_b_out | output | 1 | Channel-N-end serial pin, output side |
| port_b_oe | output | 1 | Channel-N-end serial pin drive enable |
| level_code | output | 2*N | Per-channel 2-bit drive-level code |

## Verification
The bench keeps a reference chain. Before each active edge it drives the line clock to the inactive level and checks that nothing moved; a design that decoded the wrong polarity, or shifted on both edges, would advance twice or at the wrong moment. Randomly mixed direction, mode and alternation values catch a chain that takes its serial input from the wrong pin, lets pin data leak into master mode, or swaps the select-high and select-low codes. A directed run walks one token through all N stages in each direction and checks that it leaves on the far pin at exactly the Nth edge and not one edge early or late.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

  // 2-bit drive-level codes handed to the analog output stage
  typedef enum logic [1:0] {
    LVL_SEL_HI  = 2'b00,  // selected, alternation high
    LVL_NSEL_LO = 2'b01,  // non-selected, alternation low
    LVL_NSEL_HI = 2'b10,  // non-selected, alternation high
    LVL_SEL_LO  = 2'b11   // selected, alternation low
  } level_e;

  function automatic level_e level_of(input logic bit_sel, input logic m);
    case ({bit_sel, m})
      2'b00:   level_of = LVL_NSEL_LO;
      2'b01:   level_of = LVL_NSEL_HI;
      2'b10:   level_of = LVL_SEL_LO;
      default: level_of = LVL_SEL_HI;
    endcase
  endfunction

endpackage

// File: rtl/line_edge_det.sv
module line_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic line_clk,
  input  logic edge_rise_sel,
  output logic shift_en
);
  logic prev_q;

  // During reset the previous sample tracks the line so release is edge-free
  always_ff @(posedge clk) begin
    prev_q <= line_clk;
  end

  always_comb begin
    if (rst)
      shift_en = 1'b0;
    else if (edge_rise_sel)
      shift_en = line_clk & ~prev_q;
    else
      shift_en = ~line_clk & prev_q;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         dir_fwd,
  input  logic         ser_in,
  output logic [N-1:0] stages
);
  logic [N-1:0] stage_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      logic from_low, from_high;
      if (i == 0) begin : g_first
        assign from_low = ser_in;
      end else begin : g_mid_lo
        assign from_low = stage_q[i-1];
      end
      if (i == N-1) begin : g_last
        assign from_high = ser_in;
      end else begin : g_mid_hi
        assign from_high = stage_q[i+1];
      end

      always_ff @(posedge clk) begin
        if (rst)
          stage_q[i] <= 1'b0;
        else if (shift_en)
          stage_q[i] <= dir_fwd ? from_low : from_high;
      end
    end
  endgenerate

  assign stages = stage_q;
endmodule

// File: rtl/level_encode.sv
module level_encode
  import com_scan_pkg::*;
#(
  parameter int N = 64,
  localparam int W = 2 * N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stages,
  input  logic         alt_m,
  output logic [W-1:0] level_code
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)
          level_code[2*i +: 2] <= LVL_NSEL_LO;
        else
          level_code[2*i +: 2] <= level_of(stages[i], alt_m);
      end
    end
  endgenerate
endmodule

// File: rtl/port_dir_ctl.sv
module port_dir_ctl (
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic dir_fwd,
  input  logic frame_start,
  input  logic port_a_in,
  input  logic port_b_in,
  output logic ser_in,
  output logic port_a_oe,
  output logic port_b_oe
);
  always_comb begin
    if (master_mode)
      ser_in = frame_start;
    else if (dir_fwd)
      ser_in = port_a_in;
    else
      ser_in = port_b_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_a_oe <= 1'b0;
      port_b_oe <= 1'b0;
    end else begin
      port_a_oe <= master_mode | ~dir_fwd;
      port_b_oe <= master_mode | dir_fwd;
    end
  end
endmodule

// File: rtl/com_scan_shifter.sv
module com_scan_shifter
  import com_scan_pkg::*;
#(
  parameter int N = 64,
  localparam int W = 2 * N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         line_clk,
  input  logic         edge_rise_sel,
  input  logic         dir_fwd,
  input  logic         master_mode,
  input  logic         frame_start,
  input  logic         alt_m,
  input  logic         port_a_in,
  output logic         port_a_out,
  output logic         port_a_oe,
  input  logic         port_b_in,
  output logic         port_b_out,
  output logic         port_b_oe,
  output logic [W-1:0] level_code
);
  logic         shift_en;
  logic         ser_in;
  logic [N-1:0] stages;

  line_edge_det u_edge (
    .clk          (clk),
    .rst          (rst),
    .line_clk     (line_clk),
    .edge_rise_sel(edge_rise_sel),
    .shift_en     (shift_en)
  );

  port_dir_ctl u_dir (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .dir_fwd    (dir_fwd),
    .frame_start(frame_start),
    .port_a_in  (port_a_in),
    .port_b_in  (port_b_in),
    .ser_in     (ser_in),
    .port_a_oe  (port_a_oe),
    .port_b_oe  (port_b_oe)
  );

  scan_chain #(.N(N)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .dir_fwd (dir_fwd),
    .ser_in  (ser_in),
    .stages  (stages)
  );

  level_encode #(.N(N)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .stages    (stages),
    .alt_m     (alt_m),
    .level_code(level_code)
  );

  // End stages are flops, so the serial outputs are registered
  assign port_a_out = stages[0];
  assign port_b_out = stages[N-1];
endmodule

// File: rtl/com_scan_checker.sv
module com_scan_checker #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         line_clk,
  input logic         edge_rise_sel,
  input logic         dir_fwd,
  input logic         master_mode,
  input logic         frame_start,
  input logic         alt_m,
  input logic         port_a_in,
  input logic         port_a_out,
  input logic         port_a_oe,
  input logic         port_b_in,
  input logic         port_b_out,
  input logic         port_b_oe,
  input logic [2*N-1:0] level_code
);
  logic [1:0] exp_ch1;
  always_comb begin
    case ({port_a_out, alt_m})
      2'b00:   exp_ch1 = 2'b01;
      2'b01:   exp_ch1 = 2'b10;
      2'b10:   exp_ch1 = 2'b11;
      default: exp_ch1 = 2'b00;
    endcase
  end

  assert_oe_master_R6: assert property (@(posedge clk) disable iff (rst)
    master_mode |=> (port_a_oe && port_b_oe));

  assert_oe_slave_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && dir_fwd) |=> (!port_a_oe && port_b_oe));

  assert_oe_slave_rev_R7: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !dir_fwd) |=> (port_a_oe && !port_b_oe));

  assert_hold_on_static_line_R4: assert property (@(posedge clk) disable iff (rst)
    $stable(line_clk) |=> ($stable(port_a_out) && $stable(port_b_out)));

  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(line_clk) && edge_rise_sel && dir_fwd && !master_mode)
      |=> (port_a_out == $past(port_a_in)));

  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(line_clk) && !edge_rise_sel && !dir_fwd && !master_mode)
      |=> (port_b_out == $past(port_b_in)));

  assert_master_token_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(line_clk) && edge_rise_sel && dir_fwd && master_mode)
      |=> (port_a_out == $past(frame_start)));

  assert_level_ch1_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (level_code[1:0] == $past(exp_ch1)));
endmodule

bind com_scan_shifter com_scan_checker #(.N(N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .line_clk     (line_clk),
  .edge_rise_sel(edge_rise_sel),
  .dir_fwd      (dir_fwd),
  .master_mode  (master_mode),
  .frame_start  (frame_start),
  .alt_m        (alt_m),
  .port_a_in    (port_a_in),
  .port_a_out   (port_a_out),
  .port_a_oe    (port_a_oe),
  .port_b_in    (port_b_in),
  .port_b_out   (port_b_out),
  .port_b_oe    (port_b_oe),
  .level_code   (level_code)
);

// File: tb/com_scan_shifter_tb.sv
module com_scan_shifter_tb;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_clk = 1'b0, edge_rise_sel = 1'b1, dir_fwd = 1'b1, master_mode = 1'b0;
  logic frame_start = 1'b0, alt_m = 1'b0, port_a_in = 1'b0, port_b_in = 1'b0;
  logic port_a_out, port_a_oe, port_b_out, port_b_oe;
  logic [2*N-1:0] level_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [N-1:0] model = '0;

  always #5 clk = ~clk;

  com_scan_shifter #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .line_clk(line_clk), .edge_rise_sel(edge_rise_sel),
    .dir_fwd(dir_fwd), .master_mode(master_mode), .frame_start(frame_start),
    .alt_m(alt_m), .port_a_in(port_a_in), .port_a_out(port_a_out),
    .port_a_oe(port_a_oe), .port_b_in(port_b_in), .port_b_out(port_b_out),
    .port_b_oe(port_b_oe), .level_code(level_code)
  );

  function automatic logic [1:0] exp_level(input logic b, input logic m);
    if (!b) return m ? 2'b10 : 2'b01;
    return m ? 2'b00 : 2'b11;
  endfunction

  function automatic logic [2*N-1:0] exp_levels(input logic [N-1:0] s, input logic m);
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++) v[2*k +: 2] = exp_level(s[k], m);
    return v;
  endfunction

  task automatic check1(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check1({"R8 R2 R3 levels ", tag}, level_code, exp_levels(model, alt_m));
    check1({"R9 pins ", tag}, {126'd0, port_a_out, port_b_out}, {126'd0, model[0], model[N-1]});
    check1({"R6 R7 oe ", tag}, {126'd0, port_a_oe, port_b_oe},
           {126'd0, master_mode | ~dir_fwd, master_mode | dir_fwd});
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One line: inactive transition (must not shift, R4), then active edge
  task automatic line_step();
    logic sin;
    line_clk = edge_rise_sel ? 1'b0 : 1'b1;
    wait_clks(3);
    check_all("R4 no shift on inactive edge");
    sin = master_mode ? frame_start : (dir_fwd ? port_a_in : port_b_in);
    line_clk = ~line_clk;
    wait_clks(3);
    if (dir_fwd) model = {model[N-2:0], sin};
    else         model = {sin, model[N-1:1]};
    check_all("R2 R3 R5 after active edge");
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    int seed;
    logic got;
    seed = 1234;
    void'($urandom(seed));
    wait_clks(4);
    rst = 1'b0;
    wait_clks(3);
    // R1: reset state
    check1("R1 reset levels", level_code, exp_levels('0, 1'b0));
    check1("R1 reset pins", {126'd0, port_a_out, port_b_out}, '0);

    // Directed: forward token walk, rising edge, slave (R2 R9)
    port_a_in = 1'b1;
    line_step();
    port_a_in = 1'b0;
    got = 1'b0;
    for (int p = 2; p <= N; p++) begin
      line_step();
      if (p == N-1) check1("R9 token not early on B", {127'd0, port_b_out}, '0);
    end
    check1("R9 token at B after N edges", {127'd0, port_b_out}, {127'd0, 1'b1});

    // Directed: reverse walk, falling edge (R3 R4)
    line_step();
    edge_rise_sel = 1'b0; dir_fwd = 1'b0; alt_m = 1'b1;
    port_b_in = 1'b1;
    line_step();
    port_b_in = 1'b0;
    for (int p = 2; p <= N; p++) line_step();
    check1("R3 token at A after N edges", {127'd0, port_a_out}, {127'd0, 1'b1});

    // Directed: master mode ignores pins (R5 R6)
    master_mode = 1'b1; port_a_in = 1'b1; port_b_in = 1'b1; frame_start = 1'b0;
    for (int p = 0; p < 4; p++) line_step();
    frame_start = 1'b1;
    line_step();
    check1("R5 master injects frame token at N end", {127'd0, port_b_out}, {127'd0, 1'b1});
    frame_start = 1'b0;

    // Static line clock holds state (R4)
    wait_clks(10);
    check_all("R4 static line clock");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 8 == 0) master_mode = $urandom;
      if ($urandom % 5 == 0) dir_fwd = $urandom;
      if ($urandom % 6 == 0) edge_rise_sel = $urandom;
      alt_m = $urandom;
      port_a_in = $urandom;
      port_b_in = $urandom;
      frame_start = ($urandom % 16 == 0);
      line_step();
    end

    // Synchronous reset mid-run (R1)
    rst = 1'b1;
    wait_clks(3);
    rst = 1'b0;
    model = '0;
    wait_clks(2);
    check_all("R1 reset clears");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule